// File: doc/BRIEF.md
# Destructive-Readout Memory Cycle Controller

This block sits between a synchronous processor-side port and an asynchronous memory bus that reaches core storage whose readout erases the stored word. The processor issues one of three cycle types (read with restore, clear and write, or read-modify-write) together with an address, an odd address parity bit and a word count. The controller runs each word as a four-phase request/acknowledge exchange on the memory bus. After every read it writes the word back, because the read has wiped the location. A read-modify-write keeps the location busy between its two halves.

Each transfer is checked for address parity and data parity. A missing acknowledge is treated as a reference to nonexistent memory. Every error is latched into a sticky error register, and a cycle that met an error ends with an error flag. A diagnostic cycle reads the error register and the mode bits, or clears chosen error bits and selects loop-around mode. In loop-around mode, processor write data comes back on the read path and the memory bus stays idle.

Top module: `core_mem_cycler`

## Requirements
- R1: After reset `cpu_ready` is 1, `mem_req` is 0 and a diagnostic status read returns all zeros.
- R2: A read/restore cycle (op 0) returns the stored word and its parity bit on `cpu_rdata`/`cpu_rpar` with `cpu_rvalid`. It then issues a write of that same word and parity to the same address. `mem_addr`, `mem_we` and `mem_wdata` stay stable while `mem_req` is held.
- R3: A word count `cpu_len` of n (0..3) makes op 0 and op 1 transfer n+1 words at consecutive ascending addresses. Each read word gets its own restore before the next address is touched.
- R4: A clear/write cycle (op 1) writes each processor word into its location. `cpu_wtake` pulses once after each word is taken, and the next word is then presented.
- R5: A read-modify-write cycle (op 2) returns the stored word and then waits for `cpu_mvalid`. It writes that modified word to the same address, and the memory bus carries nothing else in between.
- R6: Op 2 with a non-zero `cpu_len` is refused with no bus activity. `cpu_done` and `cpu_err` rise in the cycle after acceptance, and error bit 4 is set.
- R7: An address whose parity is not odd (`cpu_apar` must make the ones count of address plus parity odd) refuses any op 0..2 with no bus activity and an error. Error bit 1 is set.
- R8: A read word whose parity is not odd sets error bit 2. The word is still returned, is still restored unchanged, and the cycle ends with `cpu_err`.
- R9: A processor write word whose parity is not odd sets error bit 3. That word and any later words are not written, and the cycle ends with `cpu_err`.
- R10: If no synchronized acknowledge arrives within 32 cycles of raising `mem_req`, the request is dropped after exactly 32 cycles, error bit 0 is set and the rest of the cycle is abandoned with `cpu_err`.
- R11: While `mem_req` is high, `mem_apar` is the odd parity of `mem_addr`.
- R12: A diagnostic read (op 3, `cpu_addr[0]`=0) returns status with the error bits at [4:0], the loop-around enable at bit 8 and zeros elsewhere. `cpu_rpar` is odd parity over that status.
- R13: Error bits are sticky. A diagnostic write (op 3, `cpu_addr[0]`=1) clears only the bits set in `cpu_wdata[4:0]` and loads the loop-around enable from `cpu_wdata[8]`.
- R14: With loop-around enabled, no cycle raises `mem_req`. Write words are echoed on the read path, and reads (including the read half of op 2) return the last word looped; the modified word of op 2 becomes the new looped word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Start a cycle, taken when `cpu_ready` is 1 |
| cpu_op | input | 2 | 0 read/restore, 1 clear/write, 2 read-modify-write, 3 diagnostic |
| cpu_addr | input | ADDR_W | Word address; bit 0 picks diagnostic read or write |
| cpu_apar | input | 1 | Odd parity over `cpu_addr` |
| cpu_len | input | LEN_W | Number of words minus one |
| cpu_wdata | input | DATA_W | Write word, modified word, or diagnostic control |
| cpu_wpar | input | 1 | Odd parity over `cpu_wdata` |
| cpu_mvalid | input | 1 | Modified word for op 2 is present |
| cpu_ready | output | 1 | Controller idle |
| cpu_rvalid | output | 1 | Read word valid for one cycle |
| cpu_rdata | output | DATA_W | Read word or status |
| cpu_rpar | output | 1 | Parity carried with `cpu_rdata` |
| cpu_wtake | output | 1 | A write or modified word was taken in the previous edge |
| cpu_done | output | 1 | Cycle finished, one-cycle pulse |
| cpu_err | output | 1 | Finished cycle met an error, valid with `cpu_done` |
| mem_req | output | 1 | Memory bus request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_apar | output | 1 | Odd parity over `mem_addr` |
| mem_wdata | output | DATA_W | Memory write word |
| mem_wpar | output | 1 | Parity carried with `mem_wdata` |
| mem_ack | input | 1 | Asynchronous acknowledge from memory |
| mem_rdata | input | DATA_W | Read word, held while `mem_ack` is high |
| mem_rpar | input | 1 | Parity stored with the read word |

## Verification
The hardest states to reach are those where the memory itself misbehaves in the middle of a multi-word cycle. Examples are a location stored with bad parity that must still be restored unchanged, and a word count that runs off the end of populated storage, so that the second word times out after the first has already been read and restored. The bench reaches them through its memory model, which really erases a word on every read. It can also be loaded with a bad-parity word, and it stays silent for addresses above its sixteen populated words. Sweeps over every address, word count and acknowledge delay then show, from the model's transaction log and stored contents, that each read was paired with the correct restore and that abandoned words were never touched.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [1:0] {
        OP_RDRS = 2'd0,
        OP_CLRW = 2'd1,
        OP_RMW  = 2'd2,
        OP_DIAG = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_WORD = 3'd1,
        S_BREQ = 3'd2,
        S_BREL = 3'd3,
        S_MODW = 3'd4
    } st_e;

    localparam int ERR_W    = 5;
    localparam int E_NXM    = 0;
    localparam int E_APE    = 1;
    localparam int E_RDP    = 2;
    localparam int E_WDP    = 3;
    localparam int E_RML    = 4;
    localparam int LOOP_BIT = 8;

endpackage

// File: rtl/mcc_sync.sv
module mcc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/mcc_timer.sv
module mcc_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = run ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // request has waited its full window in this cycle
    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/mcc_errreg.sv
module mcc_errreg
    import mcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] set_mask,
    input  logic [ERR_W-1:0] clr_mask,
    input  logic             loop_wr,
    input  logic             loop_val,
    output logic [ERR_W-1:0] err_q,
    output logic             loop_q
);
    logic [ERR_W-1:0] err_d;
    logic             loop_d;

    always_comb begin
        err_d  = (err_q & ~clr_mask) | set_mask;
        loop_d = loop_wr ? loop_val : loop_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= '0;
            loop_q <= 1'b0;
        end else begin
            err_q  <= err_d;
            loop_q <= loop_d;
        end
    end
endmodule

// File: rtl/core_mem_cycler.sv
module core_mem_cycler
    import mcc_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int ADDR_W      = 22,
    parameter int LEN_W       = 2,
    parameter int NXM_LIMIT   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_apar,
    input  logic [LEN_W-1:0]  cpu_len,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wpar,
    input  logic              cpu_mvalid,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rpar,
    output logic              cpu_wtake,
    output logic              cpu_done,
    output logic              cpu_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_apar,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wpar,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rpar
);
    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  cnt;
        logic              we;
        logic [DATA_W-1:0] wbuf;
        logic              bpar;
        logic [DATA_W-1:0] lbuf;
        logic              lpar;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              rpar;
        logic              wtake;
        logic              done;
        logic              err;
        logic              cerr;
    } regs_t;

    regs_t r_q, r_d;

    logic [ERR_W-1:0]  set_mask, clr_mask;
    logic              loop_wr, loop_val;
    logic [ERR_W-1:0]  err_bits;
    logic              loop_on;
    logic              ack_s;
    logic              nxm_hit;
    logic              run_timer;
    logic [DATA_W-1:0] status;
    op_e               req_op;
    logic              adv, fin, fin_err;
    logic              apar_ok, wpar_ok, rpar_ok;

    mcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (mem_ack),
        .dout (ack_s)
    );

    assign run_timer = (r_q.st == S_BREQ) && !ack_s;

    mcc_timer #(.LIMIT(NXM_LIMIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_timer),
        .expired(nxm_hit)
    );

    mcc_errreg u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mask(set_mask),
        .clr_mask(clr_mask),
        .loop_wr (loop_wr),
        .loop_val(loop_val),
        .err_q   (err_bits),
        .loop_q  (loop_on)
    );

    assign req_op  = op_e'(cpu_op);
    assign apar_ok = ((~^cpu_addr) == cpu_apar);
    assign wpar_ok = ((~^cpu_wdata) == cpu_wpar);
    assign rpar_ok = ((~^mem_rdata) == mem_rpar);

    always_comb begin
        status                  = '0;
        status[ERR_W-1:0]       = err_bits;
        status[LOOP_BIT]        = loop_on;
    end

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        r_d.wtake  = 1'b0;
        r_d.done   = 1'b0;
        r_d.err    = 1'b0;
        set_mask   = '0;
        clr_mask   = '0;
        loop_wr    = 1'b0;
        loop_val   = 1'b0;
        adv        = 1'b0;
        fin        = 1'b0;
        fin_err    = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                if (cpu_req) begin
                    r_d.cerr = 1'b0;
                    if (req_op == OP_DIAG) begin
                        if (cpu_addr[0]) begin
                            clr_mask = cpu_wdata[ERR_W-1:0];
                            loop_wr  = 1'b1;
                            loop_val = cpu_wdata[LOOP_BIT];
                        end else begin
                            r_d.rvalid = 1'b1;
                            r_d.rdata  = status;
                            r_d.rpar   = ~^status;
                        end
                        fin = 1'b1;
                    end else if (!apar_ok) begin
                        set_mask[E_APE] = 1'b1;
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else if (req_op == OP_RMW && cpu_len != '0) begin
                        set_mask[E_RML] = 1'b1;
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else begin
                        r_d.op   = req_op;
                        r_d.addr = cpu_addr;
                        r_d.cnt  = cpu_len;
                        r_d.st   = S_WORD;
                    end
                end
            end

            S_WORD: begin
                if (r_q.op == OP_CLRW) begin
                    r_d.wtake = 1'b1;
                    if (!wpar_ok) begin
                        set_mask[E_WDP] = 1'b1;
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else if (loop_on) begin
                        r_d.lbuf   = cpu_wdata;
                        r_d.lpar   = cpu_wpar;
                        r_d.rvalid = 1'b1;
                        r_d.rdata  = cpu_wdata;
                        r_d.rpar   = cpu_wpar;
                        adv        = 1'b1;
                    end else begin
                        r_d.wbuf = cpu_wdata;
                        r_d.bpar = cpu_wpar;
                        r_d.we   = 1'b1;
                        r_d.st   = S_BREQ;
                    end
                end else if (loop_on) begin
                    r_d.rvalid = 1'b1;
                    r_d.rdata  = r_q.lbuf;
                    r_d.rpar   = r_q.lpar;
                    if (r_q.op == OP_RMW) r_d.st = S_MODW;
                    else                  adv    = 1'b1;
                end else begin
                    r_d.we = 1'b0;
                    r_d.st = S_BREQ;
                end
            end

            S_BREQ: begin
                if (ack_s) begin
                    if (!r_q.we) begin
                        r_d.wbuf   = mem_rdata;
                        r_d.bpar   = mem_rpar;
                        r_d.rvalid = 1'b1;
                        r_d.rdata  = mem_rdata;
                        r_d.rpar   = mem_rpar;
                        if (!rpar_ok) begin
                            set_mask[E_RDP] = 1'b1;
                            r_d.cerr        = 1'b1;
                        end
                    end
                    r_d.st = S_BREL;
                end else if (nxm_hit) begin
                    set_mask[E_NXM] = 1'b1;
                    fin     = 1'b1;
                    fin_err = 1'b1;
                end
            end

            S_BREL: begin
                if (!ack_s) begin
                    if (!r_q.we) begin
                        if (r_q.op == OP_RDRS) begin
                            r_d.we = 1'b1;
                            r_d.st = S_BREQ;
                        end else begin
                            r_d.st = S_MODW;
                        end
                    end else begin
                        adv = 1'b1;
                    end
                end
            end

            S_MODW: begin
                if (cpu_mvalid) begin
                    r_d.wtake = 1'b1;
                    if (!wpar_ok) begin
                        set_mask[E_WDP] = 1'b1;
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else if (loop_on) begin
                        r_d.lbuf = cpu_wdata;
                        r_d.lpar = cpu_wpar;
                        fin      = 1'b1;
                        fin_err  = r_q.cerr;
                    end else begin
                        r_d.wbuf = cpu_wdata;
                        r_d.bpar = cpu_wpar;
                        r_d.we   = 1'b1;
                        r_d.st   = S_BREQ;
                    end
                end
            end

            default: r_d.st = S_IDLE;
        endcase

        if (adv) begin
            if (r_q.cnt == '0) begin
                fin     = 1'b1;
                fin_err = r_d.cerr;
            end else begin
                r_d.cnt  = r_q.cnt - 1'b1;
                r_d.addr = r_q.addr + 1'b1;
                r_d.st   = S_WORD;
            end
        end

        if (fin) begin
            r_d.st   = S_IDLE;
            r_d.done = 1'b1;
            r_d.err  = fin_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_ready  = (r_q.st == S_IDLE);
    assign cpu_rvalid = r_q.rvalid;
    assign cpu_rdata  = r_q.rdata;
    assign cpu_rpar   = r_q.rpar;
    assign cpu_wtake  = r_q.wtake;
    assign cpu_done   = r_q.done;
    assign cpu_err    = r_q.err;
    assign mem_req    = (r_q.st == S_BREQ);
    assign mem_we     = r_q.we;
    assign mem_addr   = r_q.addr;
    assign mem_apar   = ~^r_q.addr;
    assign mem_wdata  = r_q.wbuf;
    assign mem_wpar   = r_q.bpar;
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker
    import mcc_pkg::*;
#(
    parameter int DATA_W    = 36,
    parameter int ADDR_W    = 22,
    parameter int LEN_W     = 2,
    parameter int NXM_LIMIT = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [1:0]        cpu_op,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_apar,
    input logic [LEN_W-1:0]  cpu_len,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              cpu_err,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_apar,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              ack_s,
    input logic [ERR_W-1:0]  err_bits,
    input logic              loop_on
);
    localparam int W_W = $clog2(NXM_LIMIT + 2);

    logic [W_W-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 wait_q <= '0;
        else if (!(mem_req && !ack_s)) wait_q <= '0;
        else if (wait_q != '1)      wait_q <= wait_q + 1'b1;
    end

    logic accept, diag_clr;
    assign accept   = cpu_ready && cpu_req;
    assign diag_clr = accept && (cpu_op == 2'(OP_DIAG)) && cpu_addr[0];

    // R10
    req_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q <= W_W'(NXM_LIMIT));

    // R11
    apar_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_apar == ~^mem_addr));

    // R2
    hold_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R14
    loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> !mem_req);

    // R13
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !diag_clr |=> ((err_bits & $past(err_bits)) == $past(err_bits)));

    // R6
    rmw_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_op == 2'(OP_RMW) && cpu_len != '0) |=> (cpu_done && cpu_err && !mem_req));

    // R7
    apar_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_op != 2'(OP_DIAG) && (cpu_apar == ^cpu_addr)) |=> (cpu_done && cpu_err && !mem_req));
endmodule

bind core_mem_cycler mcc_checker #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .NXM_LIMIT(NXM_LIMIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_op   (cpu_op),
    .cpu_addr (cpu_addr),
    .cpu_apar (cpu_apar),
    .cpu_len  (cpu_len),
    .cpu_ready(cpu_ready),
    .cpu_done (cpu_done),
    .cpu_err  (cpu_err),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_apar (mem_apar),
    .mem_wdata(mem_wdata),
    .ack_s    (ack_s),
    .err_bits (err_bits),
    .loop_on  (loop_on)
);

// File: tb/tb_core_mem_cycler.sv
module tb_core_mem_cycler;
    localparam int DW = 36;
    localparam int AW = 22;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic [1:0]    cpu_op = '0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_apar = 1'b1;
    logic [1:0]    cpu_len = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_wpar = 1'b1;
    logic          cpu_mvalid = 1'b0;
    logic          cpu_ready, cpu_rvalid, cpu_rpar, cpu_wtake, cpu_done, cpu_err;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req, mem_we, mem_apar, mem_wpar;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_rpar = 1'b0;

    core_mem_cycler dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
        .cpu_addr(cpu_addr), .cpu_apar(cpu_apar), .cpu_len(cpu_len),
        .cpu_wdata(cpu_wdata), .cpu_wpar(cpu_wpar), .cpu_mvalid(cpu_mvalid),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .cpu_rpar(cpu_rpar), .cpu_wtake(cpu_wtake), .cpu_done(cpu_done),
        .cpu_err(cpu_err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_apar(mem_apar), .mem_wdata(mem_wdata),
        .mem_wpar(mem_wpar), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_rpar(mem_rpar)
    );

    always #5 clk = ~clk;

    int compared = 0;
    int mismatched = 0;

    logic [DW-1:0] mem_d [NW];
    logic          mem_p [NW];
    int            nlog;
    logic          lg_we [64];
    int            lg_a  [64];
    int            apar_bad = 0;
    int            mem_delay = 2;

    logic [DW-1:0] wq [4];
    int            badw = -1;
    logic [DW-1:0] rd [8];
    logic          rp [8];
    int            nr;
    logic          last_err;
    int            reqcyc;
    logic [DW-1:0] st;

    function automatic logic [DW-1:0] pat(input int s);
        return (DW'(s) * 36'h0_1234_5679) ^ 36'hF_0F0F_0F0F;
    endfunction

    function automatic logic [DW-1:0] stat(input int errs, input bit lp);
        logic [DW-1:0] v = '0;
        v[4:0] = errs[4:0];
        v[8]   = lp;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // memory model: readout erases the word; addresses >= NW never answer
    initial begin
        int a;
        forever begin
            wait (mem_req === 1'b1);
            repeat (mem_delay) @(negedge clk);
            if (mem_apar !== ~^mem_addr) apar_bad++;
            if (mem_addr < AW'(NW)) begin
                a = int'(mem_addr);
                if (nlog < 64) begin
                    lg_we[nlog] = mem_we;
                    lg_a[nlog]  = a;
                end
                nlog++;
                if (mem_we) begin
                    mem_d[a] = mem_wdata;
                    mem_p[a] = mem_wpar;
                end else begin
                    mem_rdata = mem_d[a];
                    mem_rpar  = mem_p[a];
                    mem_d[a]  = '0;
                    mem_p[a]  = 1'b1;
                end
                mem_ack = 1'b1;
                wait (mem_req === 1'b0);
                @(negedge clk);
                mem_ack = 1'b0;
            end else begin
                wait (mem_req === 1'b0);
            end
        end
    end

    task automatic run(input int op, input int addr, input int len, input bit badap);
        logic [AW-1:0] ad = AW'(addr);
        int  wi;
        int  guard;
        bit  fin;
        bit  mvd;
        nr = 0; nlog = 0; reqcyc = 0;
        @(negedge clk);
        cpu_op    = op[1:0];
        cpu_addr  = ad;
        cpu_apar  = (~^ad) ^ badap;
        cpu_len   = len[1:0];
        cpu_wdata = wq[0];
        cpu_wpar  = (~^wq[0]) ^ (badw == 0);
        cpu_req   = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        wi = 1; guard = 0; fin = 0; mvd = 0;
        while (!fin) begin
            if (mem_req) reqcyc++;
            if (cpu_rvalid && nr < 8) begin
                rd[nr] = cpu_rdata;
                rp[nr] = cpu_rpar;
                nr++;
            end
            if (cpu_wtake) begin
                if (op == 2) begin
                    cpu_mvalid = 1'b0;
                    mvd = 1;
                end else begin
                    if (wi < 4) begin
                        cpu_wdata = wq[wi];
                        cpu_wpar  = (~^wq[wi]) ^ (badw == wi);
                    end
                    wi++;
                end
            end
            if (op == 2 && nr > 0 && !mvd && !cpu_wtake) cpu_mvalid = 1'b1;
            if (cpu_done) begin
                last_err = cpu_err;
                fin = 1;
            end else begin
                guard++;
                if (guard > 3000) begin
                    chk(0, "run hung", 64'(guard), 64'd0);
                    fin = 1;
                end
                @(negedge clk);
            end
        end
        cpu_mvalid = 1'b0;
    endtask

    task automatic diag_read(output logic [DW-1:0] s);
        run(3, 0, 0, 0);
        s = rd[0];
    endtask

    task automatic diag_write(input logic [DW-1:0] v);
        wq[0] = v;
        run(3, 1, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] old, old2;
        logic          bp;
        bit            ok;
        for (int i = 0; i < NW; i++) begin
            mem_d[i] = pat(i);
            mem_p[i] = ~^pat(i);
        end
        for (int k = 0; k < 4; k++) wq[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cpu_ready === 1'b1 && mem_req === 1'b0 && cpu_rvalid === 1'b0, "R1 idle outputs",
            {cpu_ready, mem_req, cpu_rvalid}, 3'b100);
        diag_read(st);
        chk(st === '0, "R1 status after reset", st, 0);

        // R2 read/restore over every address with varied ack delay
        for (int a = 0; a < NW; a++) begin
            mem_delay = 1 + (a % 4);
            run(0, a, 0, 0);
            ok = (nr == 1) && (rd[0] === pat(a)) && (rp[0] === ~^pat(a));
            chk(ok, "R2 read word", rd[0], pat(a));
            ok = (nlog == 2) && !lg_we[0] && lg_a[0] == a && lg_we[1] && lg_a[1] == a;
            chk(ok, "R2 read then restore same address", 64'(nlog), 64'd2);
            chk(mem_d[a] === pat(a) && mem_p[a] === ~^pat(a) && !last_err, "R2 location intact",
                mem_d[a], pat(a));
        end
        chk(apar_bad == 0, "R11 address parity on bus", 64'(apar_bad), 64'd0);

        // R3 multi-word read/restore
        for (int len = 1; len < 4; len++) begin
            for (int s = 0; s < 12; s += 4) begin
                mem_delay = len;
                run(0, s, len, 0);
                ok = (nr == len + 1) && (nlog == 2 * (len + 1)) && !last_err;
                for (int k = 0; k <= len; k++) begin
                    if (rd[k] !== pat(s + k)) ok = 0;
                    if (lg_we[2*k] || lg_a[2*k] != s + k) ok = 0;
                    if (!lg_we[2*k+1] || lg_a[2*k+1] != s + k) ok = 0;
                    if (mem_d[s + k] !== pat(s + k)) ok = 0;
                end
                chk(ok, "R3 word sequence", 64'(nr), 64'(len + 1));
            end
        end

        // R4 clear/write with every length
        for (int len = 0; len < 4; len++) begin
            for (int k = 0; k < 4; k++) wq[k] = pat(100 + len * 4 + k);
            run(1, 8, len, 0);
            ok = (nlog == len + 1) && !last_err;
            for (int k = 0; k <= len; k++) begin
                if (mem_d[8 + k] !== wq[k] || mem_p[8 + k] !== ~^wq[k]) ok = 0;
                if (!lg_we[k] || lg_a[k] != 8 + k) ok = 0;
            end
            chk(ok, "R4 written words", mem_d[8 + len], wq[len]);
        end

        // R5 read-modify-write
        for (int j = 0; j < 2; j++) begin
            int a = (j == 0) ? 2 : 11;
            old   = mem_d[a];
            wq[0] = pat(200 + a);
            run(2, a, 0, 0);
            chk(nr == 1 && rd[0] === old, "R5 returned word", rd[0], old);
            ok = (nlog == 2) && !lg_we[0] && lg_we[1] && lg_a[0] == a && lg_a[1] == a && !last_err;
            chk(ok && mem_d[a] === wq[0], "R5 modified word stored", mem_d[a], wq[0]);
        end

        // R6 read-modify-write with word count refused
        for (int len = 1; len < 4; len++) begin
            run(2, 3, len, 0);
            chk(nlog == 0 && last_err === 1'b1, "R6 refused without bus", 64'(nlog), 64'd0);
        end
        diag_read(st);
        chk(st === stat(5'h10, 0), "R6 error bit 4", st, stat(5'h10, 0));
        diag_write(36'h1F);

        // R7 bad address parity
        run(0, 4, 0, 1);
        chk(nlog == 0 && last_err === 1'b1, "R7 read refused", 64'(nlog), 64'd0);
        run(1, 4, 0, 1);
        chk(nlog == 0 && last_err === 1'b1, "R7 write refused", 64'(nlog), 64'd0);
        diag_read(st);
        chk(st === stat(5'h02, 0) && rp[0] === ~^st, "R7 R12 error bit 1", st, stat(5'h02, 0));

        // R8 bad stored parity
        bp = ~(~^pat(55));
        mem_d[5] = pat(55);
        mem_p[5] = bp;
        run(0, 5, 0, 0);
        chk(rd[0] === pat(55) && rp[0] === bp && last_err === 1'b1, "R8 word returned with error",
            rd[0], pat(55));
        chk(mem_d[5] === pat(55) && mem_p[5] === bp && nlog == 2, "R8 restored unchanged",
            mem_d[5], pat(55));
        diag_read(st);
        chk(st === stat(5'h06, 0), "R8 error bits 1 and 2", st, stat(5'h06, 0));

        // R13 partial clear, stickiness
        diag_write(36'h2);
        diag_read(st);
        chk(st === stat(5'h04, 0), "R13 only bit 1 cleared", st, stat(5'h04, 0));
        mem_p[5] = ~^pat(55);
        run(0, 6, 0, 0);
        diag_read(st);
        chk(st === stat(5'h04, 0), "R13 bit stays after clean cycle", st, stat(5'h04, 0));
        diag_write(36'h1F);
        diag_read(st);
        chk(st === '0, "R13 full clear", st, 0);

        // R9 bad write word parity on second word
        old2 = mem_d[10];
        wq[0] = pat(60);
        wq[1] = pat(61);
        badw  = 1;
        run(1, 9, 1, 0);
        badw = -1;
        chk(mem_d[9] === pat(60) && mem_d[10] === old2 && nlog == 1 && last_err === 1'b1,
            "R9 bad word not written", mem_d[10], old2);
        diag_read(st);
        chk(st === stat(5'h08, 0), "R9 error bit 3", st, stat(5'h08, 0));
        diag_write(36'h1F);

        // R10 nonexistent memory
        mem_delay = 2;
        run(0, 20, 0, 0);
        chk(nlog == 0 && reqcyc == 32 && last_err === 1'b1, "R10 request window", 64'(reqcyc), 64'd32);
        diag_read(st);
        chk(st === stat(5'h01, 0), "R10 error bit 0", st, stat(5'h01, 0));
        diag_write(36'h1F);
        run(0, 15, 2, 0);
        chk(nr == 1 && nlog == 2 && last_err === 1'b1 && mem_d[15] === pat(15),
            "R10 rest abandoned", 64'(nlog), 64'd2);
        diag_write(36'h1F);

        // R14 loop-around
        diag_write(36'h100);
        diag_read(st);
        chk(st === stat(0, 1), "R12 R13 loop bit reported", st, stat(0, 1));
        old = mem_d[0];
        for (int k = 0; k < 4; k++) wq[k] = pat(300 + k);
        run(1, 0, 3, 0);
        ok = (nr == 4) && (nlog == 0) && (reqcyc == 0) && !last_err;
        for (int k = 0; k < 4; k++) if (rd[k] !== wq[k]) ok = 0;
        chk(ok && mem_d[0] === old, "R14 write echoed", rd[3], pat(303));
        run(0, 0, 0, 0);
        chk(rd[0] === pat(303) && nlog == 0, "R14 read returns last looped", rd[0], pat(303));
        wq[0] = pat(400);
        run(2, 0, 0, 0);
        chk(rd[0] === pat(303) && nlog == 0, "R14 modify read half", rd[0], pat(303));
        run(0, 0, 0, 0);
        chk(rd[0] === pat(400) && nlog == 0, "R14 modified word looped", rd[0], pat(400));
        diag_write(36'h0);
        run(0, 0, 0, 0);
        chk(rd[0] === old && nlog == 2, "R14 loop off reaches memory", rd[0], old);
        chk(apar_bad == 0, "R11 address parity overall", 64'(apar_bad), 64'd0);

        summary();
        $finish;
    end
endmodule